// File: doc/BRIEF.md
# DMA Transfer Error-Handling Controller

This controller sits next to a DMA backend and decides what happens after the bus returns an error. The backend pushes the address of every burst it issues into a small metadata queue. Each read or write response that the controller accepts retires the oldest entry. An error-free response only retires its entry. An erroneous response reports the error type and the burst address to the frontend and parks the controller in a wait state. The controller then waits for a continue-or-abort decision, which counts only when it arrives with its valid strobe.

A write error on the final burst of a transfer uses its own wait state. If the decision there is to continue, the controller emits one extra response pulse to the frontend before going back to idle. An abort from either wait state starts a flush of the remaining legs. The flush request is held until the backend confirms it, and at that point the queued metadata is discarded. An idle decision input, or one presented without its strobe, never moves the controller.

Top module: `dma_err_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the controller in idle with an empty queue. While reset is low and after it is released, `rsp_ready_o`, `err_valid_o`, `extra_rsp_o` and `flush_o` are 0 and `meta_ready_o` is 1.
- R2: The metadata queue holds up to DEPTH entries (default 4) in arrival order. `meta_ready_o` is 0 while the queue is full, and a push while full is dropped. Responses retire entries oldest first.
- R3: In idle with a non-empty queue, `rsp_ready_o` is 1. An accepted response with `rsp_err_i`=0 retires one entry, raises no error report and leaves the controller in idle.
- R4: An accepted response with `rsp_err_i`=1 makes `err_valid_o` 1 for exactly the next cycle. In that cycle `err_is_write_o` equals the response's write flag and `err_addr_o` equals the address of the entry the response retired.
- R5: Outside idle, `rsp_ready_o` is 0.
- R6: A read error, or a write error with `rsp_last_i`=0, enters the general wait state. The controller stays there for every cycle in which `dec_valid_i` is 0, whatever `dec_i` holds. A valid decision of 0 (continue) returns it to idle on the next edge.
- R7: A write error with `rsp_last_i`=1 enters the last-burst wait state, which also holds while `dec_valid_i` is 0. A valid continue (0) there makes `extra_rsp_o` 1 for exactly one cycle, starting the next cycle, and the controller is in idle the cycle after.
- R8: A valid decision of 1 (abort) in either wait state makes `flush_o` 1 from the next cycle. `flush_o` stays 1 until a cycle with `flush_done_i`=1. On the next edge the controller returns to idle and the queue is emptied.
- R9: The last-burst flag has no effect on read errors: a read error with `rsp_last_i`=1 followed by continue gives no extra response.
- R10: In idle, `dec_valid_i` and `dec_i` have no effect: no flush starts and the controller stays ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| meta_push_i | input | 1 | Push a burst address into the queue |
| meta_addr_i | input | AW | Burst address to queue |
| meta_ready_o | output | 1 | Queue has room |
| rsp_valid_i | input | 1 | Response present |
| rsp_ready_o | output | 1 | Response accepted this cycle when valid |
| rsp_is_write_i | input | 1 | Response belongs to a write (1) or read (0) |
| rsp_err_i | input | 1 | Response carries a bus error |
| rsp_last_i | input | 1 | Response is for the last burst of the transfer |
| err_valid_o | output | 1 | One-cycle error report |
| err_is_write_o | output | 1 | Reported error came from a write |
| err_addr_o | output | AW | Burst address of the reported error |
| dec_valid_i | input | 1 | Decision strobe |
| dec_i | input | 1 | Decision: 0 continue, 1 abort |
| extra_rsp_o | output | 1 | Extra response pulse after a continued last-burst write error |
| flush_o | output | 1 | Request to flush remaining legs |
| flush_done_i | input | 1 | Flush finished |

## Verification
All results depend on registered state and change one clock edge after their cause. The error report appears in the cycle after the response is accepted. The extra pulse or the flush request appears in the cycle after the valid decision. The idle-ready flag returns in the cycle after continue, or one cycle later on the last-burst path, and in the cycle after the flush is confirmed. The bench changes inputs on the falling edge and reads outputs on the following falling edge, once per edge, so every check lands in the exact cycle the requirement names. It sweeps direction, error, last flag, decision and hold length, and during each hold it checks that nothing moves.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_WAIT      = 3'd1,
      ST_WAIT_LAST = 3'd2,
      ST_EMIT      = 3'd3,
      ST_FLUSH     = 3'd4
   } eh_state_e;

   typedef enum logic {
      DEC_GO   = 1'b0,
      DEC_STOP = 1'b1
   } eh_dec_e;

endpackage

// File: rtl/dma_err_meta_fifo.sv
module dma_err_meta_fifo #(
   parameter int DEPTH = 4,
   parameter int AW    = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clear_i,
   input  logic          push_i,
   input  logic [AW-1:0] data_i,
   input  logic          pop_i,
   output logic [AW-1:0] head_o,
   output logic          full_o,
   output logic          empty_o
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
      assert (AW >= 1) else $error("AW must be at least 1");
   end

   logic [AW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign full_o  = (count == CW'(DEPTH));
   assign empty_o = (count == '0);
   assign do_push = push_i && !full_o && !clear_i;
   assign do_pop  = pop_i && !empty_o && !clear_i;
   assign head_o  = mem[rd_ptr];

   generate
      if ((1 << PW) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + PW'(1);
         assign rd_nxt = rd_ptr + PW'(1);
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (do_push) mem[wr_ptr] <= data_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clear_i) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         if (do_push && !do_pop)      count <= count + CW'(1);
         else if (do_pop && !do_push) count <= count - CW'(1);
      end
   end

   assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count <= CW'(DEPTH));

   assert_pop_nonempty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_i |-> !empty_o);

   assert_full_blocks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_o && !pop_i && !clear_i) |=> full_o);

endmodule

// File: rtl/dma_err_fsm.sv
module dma_err_fsm
   import dma_err_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          take_i,
   input  logic          rsp_is_write_i,
   input  logic          rsp_err_i,
   input  logic          rsp_last_i,
   input  logic [AW-1:0] head_addr_i,
   input  logic          dec_valid_i,
   input  logic          dec_i,
   input  logic          flush_done_i,
   output logic          idle_o,
   output logic          extra_rsp_o,
   output logic          flush_o,
   output logic          clear_o,
   output logic          err_valid_o,
   output logic          err_is_write_o,
   output logic [AW-1:0] err_addr_o
);
   eh_state_e st, st_nxt;
   eh_dec_e   dec;
   logic      hit_err;

   assign dec     = eh_dec_e'(dec_i);
   assign hit_err = (st == ST_IDLE) && take_i && rsp_err_i;

   always_comb begin
      st_nxt  = st;
      clear_o = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (hit_err) st_nxt = (rsp_is_write_i && rsp_last_i) ? ST_WAIT_LAST : ST_WAIT;
         end
         ST_WAIT: begin
            if (dec_valid_i) st_nxt = (dec == DEC_STOP) ? ST_FLUSH : ST_IDLE;
         end
         ST_WAIT_LAST: begin
            if (dec_valid_i) st_nxt = (dec == DEC_STOP) ? ST_FLUSH : ST_EMIT;
         end
         ST_EMIT: st_nxt = ST_IDLE;
         ST_FLUSH: begin
            if (flush_done_i) begin
               st_nxt  = ST_IDLE;
               clear_o = 1'b1;
            end
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st             <= ST_IDLE;
         err_valid_o    <= 1'b0;
         err_is_write_o <= 1'b0;
         err_addr_o     <= '0;
      end else begin
         st          <= st_nxt;
         err_valid_o <= hit_err;
         if (hit_err) begin
            err_is_write_o <= rsp_is_write_i;
            err_addr_o     <= head_addr_i;
         end
      end
   end

   assign idle_o      = (st == ST_IDLE);
   assign extra_rsp_o = (st == ST_EMIT);
   assign flush_o     = (st == ST_FLUSH);

   assert_err_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_valid_o |=> !err_valid_o);

   assert_hold_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st == ST_WAIT && !dec_valid_i) |=> (st == ST_WAIT));

   assert_hold_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st == ST_WAIT_LAST && !dec_valid_i) |=> (st == ST_WAIT_LAST));

   assert_extra_once_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      extra_rsp_o |=> !extra_rsp_o);

   assert_flush_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_o && !flush_done_i) |=> flush_o);

   assert_idle_dec_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (idle_o && !(take_i && rsp_err_i)) |=> idle_o);

endmodule

// File: rtl/dma_err_ctrl.sv
module dma_err_ctrl #(
   parameter int DEPTH = 4,
   parameter int AW    = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          meta_push_i,
   input  logic [AW-1:0] meta_addr_i,
   output logic          meta_ready_o,
   input  logic          rsp_valid_i,
   output logic          rsp_ready_o,
   input  logic          rsp_is_write_i,
   input  logic          rsp_err_i,
   input  logic          rsp_last_i,
   output logic          err_valid_o,
   output logic          err_is_write_o,
   output logic [AW-1:0] err_addr_o,
   input  logic          dec_valid_i,
   input  logic          dec_i,
   output logic          extra_rsp_o,
   output logic          flush_o,
   input  logic          flush_done_i
);
   logic          full, empty, idle, take, clear;
   logic [AW-1:0] head;

   assign meta_ready_o = !full;
   assign rsp_ready_o  = idle && !empty;
   assign take         = rsp_valid_i && rsp_ready_o;

   dma_err_meta_fifo #(.DEPTH(DEPTH), .AW(AW)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (clear),
      .push_i  (meta_push_i),
      .data_i  (meta_addr_i),
      .pop_i   (take),
      .head_o  (head),
      .full_o  (full),
      .empty_o (empty)
   );

   dma_err_fsm #(.AW(AW)) u_fsm (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .take_i         (take),
      .rsp_is_write_i (rsp_is_write_i),
      .rsp_err_i      (rsp_err_i),
      .rsp_last_i     (rsp_last_i),
      .head_addr_i    (head),
      .dec_valid_i    (dec_valid_i),
      .dec_i          (dec_i),
      .flush_done_i   (flush_done_i),
      .idle_o         (idle),
      .extra_rsp_o    (extra_rsp_o),
      .flush_o        (flush_o),
      .clear_o        (clear),
      .err_valid_o    (err_valid_o),
      .err_is_write_o (err_is_write_o),
      .err_addr_o     (err_addr_o)
   );

   assert_busy_closed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_valid_o || flush_o || extra_rsp_o) |-> !rsp_ready_o);

   assert_clear_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_o && flush_done_i) |=> !rsp_ready_o);

endmodule

// File: tb/tb_dma_err_ctrl.sv
module tb_dma_err_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 4;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic          meta_push_i = 1'b0;
   logic [AW-1:0] meta_addr_i = '0;
   logic          meta_ready_o;
   logic          rsp_valid_i = 1'b0;
   logic          rsp_ready_o;
   logic          rsp_is_write_i = 1'b0;
   logic          rsp_err_i = 1'b0;
   logic          rsp_last_i = 1'b0;
   logic          err_valid_o;
   logic          err_is_write_o;
   logic [AW-1:0] err_addr_o;
   logic          dec_valid_i = 1'b0;
   logic          dec_i = 1'b0;
   logic          extra_rsp_o;
   logic          flush_o;
   logic          flush_done_i = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_err_ctrl #(.DEPTH(DEPTH), .AW(AW)) dut (
      .clk_i(clk), .rst_ni(rst_ni),
      .meta_push_i(meta_push_i), .meta_addr_i(meta_addr_i), .meta_ready_o(meta_ready_o),
      .rsp_valid_i(rsp_valid_i), .rsp_ready_o(rsp_ready_o),
      .rsp_is_write_i(rsp_is_write_i), .rsp_err_i(rsp_err_i), .rsp_last_i(rsp_last_i),
      .err_valid_o(err_valid_o), .err_is_write_o(err_is_write_o), .err_addr_o(err_addr_o),
      .dec_valid_i(dec_valid_i), .dec_i(dec_i),
      .extra_rsp_o(extra_rsp_o), .flush_o(flush_o), .flush_done_i(flush_done_i)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic push(input logic [AW-1:0] a);
      meta_push_i = 1'b1;
      meta_addr_i = a;
      tick();
      meta_push_i = 1'b0;
   endtask

   task automatic respond(input logic w, input logic e, input logic l);
      rsp_valid_i    = 1'b1;
      rsp_is_write_i = w;
      rsp_err_i      = e;
      rsp_last_i     = l;
      tick();
      rsp_valid_i = 1'b0;
      rsp_err_i   = 1'b0;
      rsp_last_i  = 1'b0;
   endtask

   task automatic decide(input logic d);
      dec_valid_i = 1'b1;
      dec_i       = d;
      tick();
      dec_valid_i = 1'b0;
      dec_i       = 1'b0;
   endtask

   task automatic quiet(input string req);
      check({req, " no extra"}, extra_rsp_o, 0);
      check({req, " no flush"}, flush_o, 0);
      check("R5 closed", rsp_ready_o, 0);
   endtask

   initial begin
      repeat (3) tick();
      check("R1 ready in reset", rsp_ready_o, 0);
      check("R1 meta ready", meta_ready_o, 1);
      rst_ni = 1'b1;
      tick();
      check("R1 rsp ready", rsp_ready_o, 0);
      check("R1 err valid", err_valid_o, 0);
      check("R1 extra", extra_rsp_o, 0);
      check("R1 flush", flush_o, 0);

      // R2: fill, overfill, ordering
      for (int k = 0; k < DEPTH + 1; k++) begin
         push(AW'(16'h0A00 + k));
         if (k == DEPTH - 1) check("R2 full", meta_ready_o, 0);
      end
      for (int k = 0; k < DEPTH - 1; k++) begin
         check("R3 ready", rsp_ready_o, 1);
         respond(1'b0, 1'b0, 1'b0);
         check("R3 no report", err_valid_o, 0);
      end
      check("R2 room", meta_ready_o, 1);
      respond(1'b0, 1'b1, 1'b0);
      check("R2 order addr", err_addr_o, 32'h0A00 + DEPTH - 1);
      decide(1'b0);
      check("R2 overfill dropped", rsp_ready_o, 0);

      // sweep
      for (int it = 0; it < 32; it++) begin
         automatic logic w = it[0];
         automatic logic e = it[1];
         automatic logic l = it[2];
         automatic logic d = it[3];
         automatic int   h = it[4] ? 3 : 0;
         automatic logic [AW-1:0] a = AW'(16'h1000 + it * 37);
         automatic logic lastw = w && l;
         push(a);
         push(a + AW'(1));
         // R10: decision in idle ignored
         dec_valid_i = 1'b1;
         dec_i = 1'b1;
         tick();
         dec_valid_i = 1'b0;
         dec_i = 1'b0;
         check("R10 no flush", flush_o, 0);
         check("R10 still ready", rsp_ready_o, 1);
         respond(w, e, l);
         if (!e) begin
            check("R3 no report", err_valid_o, 0);
            check("R3 ready", rsp_ready_o, 1);
            respond(1'b0, 1'b0, 1'b0);
            check("R3 drained", rsp_ready_o, 0);
         end else begin
            check("R4 valid", err_valid_o, 1);
            check("R4 dir", err_is_write_o, w);
            check("R4 addr", err_addr_o, a);
            check("R5 closed", rsp_ready_o, 0);
            for (int c = 0; c < h; c++) begin
               dec_i = 1'b0;
               tick();
               check("R4 one cycle", err_valid_o, 0);
               quiet(lastw ? "R7 hold" : "R6 hold");
            end
            decide(d);
            if (d) begin
               check("R8 flush", flush_o, 1);
               check("R8 no extra", extra_rsp_o, 0);
               for (int c = 0; c < 2; c++) begin
                  tick();
                  check("R8 flush held", flush_o, 1);
               end
               flush_done_i = 1'b1;
               tick();
               flush_done_i = 1'b0;
               check("R8 flush off", flush_o, 0);
               check("R8 queue cleared", rsp_ready_o, 0);
               tick();
               check("R8 idle stays", flush_o, 0);
            end else if (lastw) begin
               check("R7 extra", extra_rsp_o, 1);
               check("R7 not ready", rsp_ready_o, 0);
               tick();
               check("R7 extra once", extra_rsp_o, 0);
               check("R7 idle", rsp_ready_o, 1);
               respond(1'b0, 1'b0, 1'b0);
            end else begin
               check(l ? "R9 no extra" : "R6 no extra", extra_rsp_o, 0);
               check("R6 idle", rsp_ready_o, 1);
               tick();
               check(l ? "R9 still none" : "R6 still none", extra_rsp_o, 0);
               respond(1'b0, 1'b0, 1'b0);
            end
         end
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule